// File: doc/BRIEF.md
# Dual-Direction AES Byte Substitution Unit

This unit substitutes one byte per clock. It performs either the forward AES S-box used for encryption or the inverse S-box used for decryption, and a mode input picks the direction on each byte. Neither direction uses a stored table. A single multiplicative-inverse core computes both: it maps the byte into a tower of GF(2^4) and GF(2^2) subfields, inverts it there with small gate networks, and maps the result back to the AES field. For decryption the byte passes through the inverse affine transform before the core. For encryption the forward affine transform is applied after the core.

In decryption mode a round-key byte is XORed into the result right after the inverse substitution. A following byte permutation moves whole bytes and does not change this per-byte XOR, so the key addition can be placed here. In encryption mode the key byte has no effect. The unit has two register stages. A valid flag travels with each byte, and the latency is the same in both directions, so a stream may change direction on every cycle.

Top module: `dual_sbox`

## Requirements
- R1: With `in_enc` = 1, `out_byte` equals the forward AES S-box of `in_byte`. The forward S-box is the GF(2^8) inverse modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map b_i = a_i ^ a_(i+4)%8 ^ a_(i+5)%8 ^ a_(i+6)%8 ^ a_(i+7)%8 ^ c_i, where c = 0x63.
- R2: With `in_enc` = 0, `out_byte` equals the inverse AES S-box of `in_byte` XORed with `in_key`.
- R3: With `in_enc` = 1, the value of `in_key` has no effect on `out_byte`.
- R4: `out_valid` is high in exactly those cycles that follow by two rising edges a cycle in which `in_valid` was high. This holds in both modes.
- R5: In encryption mode 0x00 becomes 0x63. In decryption mode 0x63 becomes the key byte, because the inverse substitution of 0x63 is 0x00.
- R6: While `rst_n` is low, `out_valid` and `out_byte` are 0.
- R7: In a cycle where `out_valid` is low, `out_byte` keeps its previous value.
- R8: Back-to-back bytes with a different mode on each cycle each get the result of their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_enc | input | 1 | 1 = forward substitution, 0 = inverse substitution plus key XOR |
| in_byte | input | 8 | Byte to substitute |
| in_key | input | 8 | Round-key byte, used in decryption mode only |
| out_valid | output | 1 | Result byte is present this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench sweeps all 256 inputs in each direction against tables it builds itself by brute-force field inversion. The encryption sweep uses a varying key, and a repeat of some inputs with a different key shows that the key is ignored. The decryption sweep uses a key that changes per byte, which separates a missing key XOR from a wrong inverse. The bench also sends streams that alternate modes on every cycle, to catch a mode that is taken from the wrong stage. Bursts with gaps check the valid timing and that the output holds in idle cycles.

// File: rtl/sbox_gf_pkg.sv
package sbox_gf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int DIB_W  = NIB_W / 2;
    localparam int FIELD_N = 1 << BYTE_W;
    localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
    localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;
    localparam logic [DIB_W-1:0]  NU = 2'b10;

    typedef struct packed {
        logic             vld;
        logic             enc;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] delta;
        logic [BYTE_W-1:0] key;
    } mid_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] res;
    } fin_t;

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] fwd_affine(input logic [7:0] a);
        return a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ FWD_CONST;
    endfunction

    function automatic logic [7:0] inv_affine(input logic [7:0] a);
        return rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ INV_CONST;
    endfunction

    // GF(4): z^2 = z + 1
    function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
        logic hh;
        hh = a[1] & b[1];
        return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
    endfunction

    function automatic logic [1:0] gf4_sq(input logic [1:0] a);
        return {a[1], a[1] ^ a[0]};
    endfunction

    // GF(16) over GF(4): x^2 = x + NU
    function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
        logic [1:0] hh;
        hh = gf4_mul(a[3:2], b[3:2]);
        return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
                gf4_mul(hh, NU) ^ gf4_mul(a[1:0], b[1:0])};
    endfunction

    function automatic logic [3:0] gf16_inv(input logic [3:0] a);
        logic [1:0] d;
        logic [1:0] di;
        d  = gf4_mul(gf4_sq(a[3:2]), NU) ^ gf4_mul(a[3:2], a[1:0]) ^ gf4_sq(a[1:0]);
        di = gf4_sq(d);
        return {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
    endfunction

    // GF(256) over GF(16): y^2 = y + lam
    function automatic logic [7:0] tower_mul(input logic [7:0] a, input logic [7:0] b,
                                             input logic [3:0] lam);
        logic [3:0] hh;
        hh = gf16_mul(a[7:4], b[7:4]);
        return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
                gf16_mul(hh, lam) ^ gf16_mul(a[3:0], b[3:0])};
    endfunction

    function automatic logic [3:0] find_lambda();
        logic [3:0] res;
        logic found;
        logic ok;
        res = 4'h0;
        found = 1'b0;
        for (int c = 1; c < 16; c++) begin
            ok = 1'b1;
            for (int y = 0; y < 16; y++) begin
                if ((gf16_mul(4'(y), 4'(y)) ^ 4'(y)) == 4'(c)) ok = 1'b0;
            end
            if (ok && !found) begin
                res = 4'(c);
                found = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [7:0] find_root(input logic [3:0] lam);
        logic [7:0] res;
        logic [7:0] t;
        logic [7:0] t2;
        logic [7:0] t3;
        logic [7:0] t4;
        logic [7:0] t8;
        logic found;
        res = 8'h00;
        found = 1'b0;
        for (int i = 2; i < FIELD_N; i++) begin
            t  = 8'(i);
            t2 = tower_mul(t, t, lam);
            t3 = tower_mul(t2, t, lam);
            t4 = tower_mul(t2, t2, lam);
            t8 = tower_mul(t4, t4, lam);
            if (((t8 ^ t4 ^ t3 ^ t ^ 8'h01) == 8'h00) && !found) begin
                res = t;
                found = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [63:0] build_to_tower(input logic [7:0] root, input logic [3:0] lam);
        logic [63:0] m;
        logic [7:0] p;
        p = 8'h01;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m[8*i +: 8] = p;
            p = tower_mul(p, root, lam);
        end
        return m;
    endfunction

    function automatic logic [7:0] apply_map(input logic [63:0] m, input logic [7:0] a);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (a[i]) r = r ^ m[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] build_from_tower(input logic [63:0] fwd);
        logic [63:0] m;
        m = '0;
        for (int j = 0; j < 8; j++) begin
            for (int a = 0; a < FIELD_N; a++) begin
                if (apply_map(fwd, 8'(a)) == (8'h01 << j)) m[8*j +: 8] = 8'(a);
            end
        end
        return m;
    endfunction

    localparam logic [3:0]  LAMBDA   = find_lambda();
    localparam logic [7:0]  ISO_ROOT = find_root(LAMBDA);
    localparam logic [63:0] TO_TOWER = build_to_tower(ISO_ROOT, LAMBDA);
    localparam logic [63:0] FROM_TOWER = build_from_tower(TO_TOWER);

endpackage

// File: rtl/sbox_front.sv
module sbox_front
    import sbox_gf_pkg::*;
(
    input  logic              enc,
    input  logic [BYTE_W-1:0] data,
    output logic [NIB_W-1:0]  hi,
    output logic [NIB_W-1:0]  lo,
    output logic [NIB_W-1:0]  delta
);
    logic [BYTE_W-1:0] pre;
    logic [BYTE_W-1:0] tw;

    always_comb begin
        pre   = enc ? data : inv_affine(data);
        tw    = apply_map(TO_TOWER, pre);
        hi    = tw[7:4];
        lo    = tw[3:0];
        delta = gf16_mul(gf16_mul(tw[7:4], tw[7:4]), LAMBDA)
              ^ gf16_mul(tw[7:4], tw[3:0])
              ^ gf16_mul(tw[3:0], tw[3:0]);
    end
endmodule

// File: rtl/sbox_back.sv
module sbox_back
    import sbox_gf_pkg::*;
(
    input  logic              enc,
    input  logic [NIB_W-1:0]  hi,
    input  logic [NIB_W-1:0]  lo,
    input  logic [NIB_W-1:0]  delta,
    input  logic [BYTE_W-1:0] key,
    output logic [BYTE_W-1:0] tower_inv,
    output logic [BYTE_W-1:0] res
);
    logic [NIB_W-1:0]  dinv;
    logic [BYTE_W-1:0] plain;

    always_comb begin
        dinv      = gf16_inv(delta);
        tower_inv = {gf16_mul(hi, dinv), gf16_mul(hi ^ lo, dinv)};
        plain     = apply_map(FROM_TOWER, tower_inv);
        res       = enc ? fwd_affine(plain) : (plain ^ key);
    end
endmodule

// File: rtl/dual_sbox.sv
module dual_sbox
    import sbox_gf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_enc,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [BYTE_W-1:0] in_key,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    mid_t mid_d, mid_q;
    fin_t fin_d, fin_q;

    logic [NIB_W-1:0]  f_hi, f_lo, f_delta;
    logic [BYTE_W-1:0] b_inv, b_res;

    sbox_front u_front (
        .enc   (in_enc),
        .data  (in_byte),
        .hi    (f_hi),
        .lo    (f_lo),
        .delta (f_delta)
    );

    sbox_back u_back (
        .enc       (mid_q.enc),
        .hi        (mid_q.hi),
        .lo        (mid_q.lo),
        .delta     (mid_q.delta),
        .key       (mid_q.key),
        .tower_inv (b_inv),
        .res       (b_res)
    );

    always_comb begin
        mid_d     = mid_q;
        mid_d.vld = in_valid;
        if (in_valid) begin
            mid_d.enc   = in_enc;
            mid_d.hi    = f_hi;
            mid_d.lo    = f_lo;
            mid_d.delta = f_delta;
            mid_d.key   = in_key;
        end
        fin_d     = fin_q;
        fin_d.vld = mid_q.vld;
        if (mid_q.vld) fin_d.res = b_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q <= '0;
            fin_q <= '0;
        end else begin
            mid_q <= mid_d;
            fin_q <= fin_d;
        end
    end

    assign out_valid = fin_q.vld;
    assign out_byte  = fin_q.res;

    // R4
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R4
    bubble_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R5
    zero_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_enc && in_byte == 8'h00) |=> ##1 (out_byte == FWD_CONST));

    // R5
    dec_63_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_enc && in_byte == FWD_CONST) |=> ##1 (out_byte == $past(in_key, 2)));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_byte));

    // R2
    tower_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_q.vld && {mid_q.hi, mid_q.lo} != 8'h00)
            |-> (tower_mul({mid_q.hi, mid_q.lo}, b_inv, LAMBDA) == 8'h01));
endmodule

// File: tb/dual_sbox_test.sv
`timescale 1ns/1ps
module dual_sbox_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_enc = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] in_key = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int checks = 0;
    int fails = 0;
    logic running = 1'b0;
    logic prev_v = 1'b0;
    logic [7:0] last_out = 8'h00;

    logic [7:0] fsb [256];
    logic [7:0] isb [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    dual_sbox uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_enc(in_enc),
        .in_byte(in_byte), .in_key(in_key), .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic e, input logic [7:0] d,
                        input logic [7:0] k, input string tag);
        @(negedge clk);
        in_valid = v;
        in_enc   = e;
        in_byte  = d;
        in_key   = k;
        if (v) begin
            exp_q.push_back(e ? fsb[d] : (isb[d] ^ k));
            tag_q.push_back(tag);
        end
    endtask

    // monitor: R4 valid timing, R7 hold, data compares
    always @(posedge clk) begin
        #1;
        if (running) begin
            check("R4 out_valid", {7'b0, out_valid}, {7'b0, prev_v});
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R4 unexpected output", 8'h01, 8'h00);
                end else begin
                    check(tag_q.pop_front(), out_byte, exp_q.pop_front());
                end
            end else begin
                check("R7 hold", out_byte, last_out);
            end
            last_out = out_byte;
            prev_v = in_valid;
        end
    end

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] inv;
        logic [7:0] s;
        for (int a = 0; a < 256; a++) begin
            inv = 8'h00;
            for (int b = 1; b < 256; b++) begin
                if (gmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
            end
            for (int i = 0; i < 8; i++) begin
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
            end
            fsb[a] = s;
        end
        for (int a = 0; a < 256; a++) isb[fsb[a]] = 8'(a);

        // R6: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R6 out_valid in reset", {7'b0, out_valid}, 8'h00);
        check("R6 out_byte in reset", out_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R1: every byte forward, key varies
        for (int i = 0; i < 256; i++) send(1'b1, 1'b1, 8'(i), 8'(i * 29 + 7), "R1 forward");
        // R3: key must not matter in encrypt mode
        for (int i = 0; i < 32; i++) send(1'b1, 1'b1, 8'(i * 8 + 3), 8'hff ^ 8'(i), "R3 key ignored");
        // R2: every byte inverse with varying key
        for (int i = 0; i < 256; i++) send(1'b1, 1'b0, 8'(i), 8'(i * 53 + 11), "R2 inverse+key");
        // R5: corner values
        send(1'b1, 1'b1, 8'h00, 8'h5a, "R5 enc zero");
        send(1'b1, 1'b0, 8'h63, 8'h00, "R5 dec 63 key 0");
        send(1'b1, 1'b0, 8'h63, 8'ha5, "R5 dec 63 key a5");
        send(1'b1, 1'b0, 8'h00, 8'h00, "R5 dec zero");
        // R8: alternate mode every cycle
        for (int i = 0; i < 128; i++)
            send(1'b1, 1'(i % 2), 8'(i * 77 + 1), 8'(i * 13), "R8 alternating");
        // R4/R7: bursts with gaps
        for (int i = 0; i < 64; i++)
            send(1'((i % 3) == 0), 1'((i % 5) < 2), 8'(i * 91), 8'(i + 100), "R4 gapped");
        repeat (5) send(1'b0, 1'b0, 8'h00, 8'h00, "idle");
        @(negedge clk);
        check("R4 all results delivered", 8'(exp_q.size()), 8'h00);
        running = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule